// File: doc/BRIEF.md
# Reservation Unit for Load-Reserve / Store-Conditional

This block holds the one reservation a processor keeps for atomic read-modify-write sequences. The core hands it requests over a valid/ready handshake: a reserving load (word or doubleword) reads memory and records a reservation on the address it used. A conditional store (word or doubleword) writes memory only if a reservation is present when the store is accepted. In both cases the store clears the reservation. The result of a conditional store is a four-bit condition field that tells software whether the write happened.

The reservation is shared by both widths. It is dropped by any conditional store, by a new reserving load (which replaces it), by a store from another agent that falls in the reserved granule, by an external clear line, and by reset. A conditional store does not compare its address with the reserved one: success depends only on whether a reservation exists. Misaligned accesses raise an alignment error. Doubleword requests on a 32-bit build raise an illegal-instruction error. In both error cases memory is not touched.

Top module: `resv_unit`

## Requirements
- R1: A reserving load reads memory at the request address and returns the data in `rspData`: the low 32 bits zero-extended for a word, all 64 bits for a doubleword. It then holds a reservation on that address, replacing any earlier reserved address.
- R2: Word and doubleword requests share one reservation. A reservation made by either load width lets a conditional store of either width succeed.
- R3: A conditional store accepted while a reservation exists performs exactly one memory write of its data (a word store writes the low 32 bits, zero-extended). It reports EQ=1, and the reservation is then gone.
- R4: A conditional store accepted with no reservation makes no memory access and reports EQ=0.
- R5: `rspCr` for a conditional store is {LT=0, GT=0, EQ=store performed, SO=`reqSo` sampled at acceptance}, with LT in bit 3 and SO in bit 0. Loads and errored requests return `rspCr`=0.
- R6: A conditional store succeeds whenever a reservation exists, even if its address differs from the reserved one.
- R7: A word address with bits [1:0]≠0, or a doubleword address with bits [2:0]≠0, gives a one-cycle `errAlign` with its response. There is no memory access, `rspData`=0, and the reservation is left as it was.
- R8: With `MODE64`=0, any doubleword request (op bit 0 set) gives `errIllegal` with its response and makes no memory access. The illegal check takes precedence over the alignment check.
- R9: A snoop (`snoopValid`) whose address lies in the same `GRAN_BYTES`-aligned granule as the reserved address clears the reservation. A snoop to another granule does not.
- R10: Reset and the `clearRsv` input clear the reservation. A clear in the same cycle as a completing reserving load wins, and the load still returns its data.
- R11: `reqReady` is high only when the unit is idle. Each accepted request yields exactly one response, with `rspValid` high for one cycle. Op encoding: 0 = load-reserve word, 1 = load-reserve doubleword, 2 = conditional-store word, 3 = conditional-store doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqOp | input | 2 | Operation: bit 1 = store, bit 0 = doubleword |
| reqAddr | input | ADDR_W | Effective address |
| reqData | input | 64 | Store data |
| reqSo | input | 1 | Summary-overflow bit to copy into the condition result |
| snoopValid | input | 1 | Another agent stored to memory |
| snoopAddr | input | ADDR_W | Address of that store |
| clearRsv | input | 1 | External reservation clear |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Access is a write |
| memDbl | output | 1 | Access is 64-bit (else 32-bit) |
| memAddr | output | ADDR_W | Access address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Memory completed the access |
| memRdata | input | 64 | Read data, valid with memAck |
| rspValid | output | 1 | Response strobe |
| rspData | output | 64 | Load data |
| rspCr | output | 4 | Condition result {LT,GT,EQ,SO} |
| errAlign | output | 1 | Alignment error, with rspValid |
| errIllegal | output | 1 | Illegal-instruction error, with rspValid |

## Verification
The reservation bit cannot be seen directly at the ports. A wrong value shows up only at the next conditional store, as a flipped EQ bit together with a write that is missing or extra. For that reason every clearing and setting event in the bench is followed at once by a conditional store, so each error surfaces within one transaction. A fault in the control sequencing shows up in the cycle after acceptance: an access on an errored request, or a `reqReady` that fails to drop. Data-path faults appear in the response that closes the same request.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // op bit 1: conditional store; op bit 0: doubleword
  typedef enum logic [1:0] {
    OP_LRW = 2'd0,
    OP_LRD = 2'd1,
    OP_SCW = 2'd2,
    OP_SCD = 2'd3
  } resvOp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;    // request accepted this cycle
    logic doStore;     // accepted conditional store will write
    logic scClear;     // accepted valid conditional store: drop reservation
    logic setRsv;      // reserving load completes this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter bit MODE64 = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [2:0] reqAddrLow,
  input  logic       rsvValid,
  input  logic       memAck,
  output logic       reqReady,
  output logic       memReq,
  output logic       rspValid,
  output logic       errAlign,
  output logic       errIllegal,
  output ctlStrobe_t strobe
);
  ctlState_e state, stateNext;
  logic isDbl, isSc, illegal, misal, errAny, fire;
  logic isScQ, errAlignQ, errIllQ;

  assign isDbl   = reqOp[0];
  assign isSc    = reqOp[1];
  assign illegal = isDbl && !MODE64;
  assign misal   = isDbl ? (reqAddrLow != 3'd0) : (reqAddrLow[1:0] != 2'd0);
  assign errAny  = illegal || misal;

  assign reqReady = (state == ST_IDLE);
  assign fire     = reqValid && reqReady;
  assign memReq   = (state == ST_MEM);
  assign rspValid = (state == ST_RESP);
  assign errAlign   = rspValid && errAlignQ;
  assign errIllegal = rspValid && errIllQ;

  always_comb begin
    strobe          = '0;
    strobe.latchReq = fire;
    strobe.scClear  = fire && isSc && !errAny;
    strobe.doStore  = fire && isSc && !errAny && rsvValid;
    strobe.setRsv   = memReq && memAck && !isScQ;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (fire) stateNext = (errAny || (isSc && !rsvValid)) ? ST_RESP : ST_MEM;
      ST_MEM:  if (memAck) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isScQ     <= 1'b0;
      errAlignQ <= 1'b0;
      errIllQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (fire) begin
        isScQ     <= isSc;
        errIllQ   <= illegal;
        errAlignQ <= misal && !illegal;
      end
    end
  end

  p_err_no_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fire && errAny) |=> (rspValid && !memReq));
  p_no_rsv_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && isSc && !errAny && !rsvValid) |=> !memReq);
  p_store_issues_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStore |=> memReq);
  p_err_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(errAlign && errIllegal));
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));
  p_busy_after_fire_r11: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> !reqReady);
endmodule

// File: rtl/resv_dpath.sv
module resv_dpath
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int GRAN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqSo,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              clearRsv,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rsvValid,
  output logic              memWe,
  output logic              memDbl,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData,
  output logic [3:0]        rspCr
);
  localparam int HALF_W   = DATA_W / 2;
  localparam int GRAN_LSB = $clog2(GRAN_BYTES);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  logic [1:0]        opQ;
  logic [ADDR_W-1:0] addrQ, rsvAddrQ;
  logic [DATA_W-1:0] dataQ, rdataQ;
  logic [3:0]        crQ;
  logic              rsvValidQ;
  logic              snoopHitHeld, snoopHitNew, anyClear;

  assign snoopHitHeld = snoopValid && rsvValidQ &&
                        ((snoopAddr & GRAN_MASK) == (rsvAddrQ & GRAN_MASK));
  assign snoopHitNew  = snoopValid && strobe.setRsv &&
                        ((snoopAddr & GRAN_MASK) == (addrQ & GRAN_MASK));
  assign anyClear = strobe.scClear || clearRsv || snoopHitHeld || snoopHitNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= '0;
      addrQ  <= '0;
      dataQ  <= '0;
      crQ    <= '0;
      rdataQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        opQ    <= reqOp;
        addrQ  <= reqAddr;
        dataQ  <= reqData;
        rdataQ <= '0;
        crQ    <= strobe.scClear ? {2'b00, strobe.doStore, reqSo} : 4'b0000;
      end
      if (strobe.setRsv)
        rdataQ <= opQ[0] ? memRdata : {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};
    end
  end

  // clearing events are applied after a set, so they win
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsvValidQ <= 1'b0;
      rsvAddrQ  <= '0;
    end else begin
      if (strobe.setRsv) begin
        rsvValidQ <= 1'b1;
        rsvAddrQ  <= addrQ;
      end
      if (anyClear) rsvValidQ <= 1'b0;
    end
  end

  assign rsvValid = rsvValidQ;
  assign memWe    = opQ[1];
  assign memDbl   = opQ[0];
  assign memAddr  = addrQ;
  assign memWdata = opQ[0] ? dataQ : {{HALF_W{1'b0}}, dataQ[HALF_W-1:0]};
  assign rspData  = rdataQ;
  assign rspCr    = crQ;

  p_ext_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearRsv |=> !rsvValid);
  p_sc_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scClear |=> !rsvValid);
  p_snoop_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && rsvValid && (snoopAddr[ADDR_W-1:GRAN_LSB] == rsvAddrQ[ADDR_W-1:GRAN_LSB]))
      |=> !rsvValid);
  p_load_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setRsv && !clearRsv && !snoopValid) |=> (rsvValid && rsvAddrQ == $past(addrQ)));
endmodule

// File: rtl/resv_unit.sv
module resv_unit
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN_BYTES = 8,
  parameter bit MODE64     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqData,
  input  logic              reqSo,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              clearRsv,
  output logic              memReq,
  output logic              memWe,
  output logic              memDbl,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic [63:0]       memRdata,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic [3:0]        rspCr,
  output logic              errAlign,
  output logic              errIllegal
);
  ctlStrobe_t strobe;
  logic       rsvValid;

  resv_ctrl #(.MODE64(MODE64)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddrLow(reqAddr[2:0]), .rsvValid(rsvValid), .memAck(memAck),
    .reqReady(reqReady), .memReq(memReq), .rspValid(rspValid),
    .errAlign(errAlign), .errIllegal(errIllegal), .strobe(strobe)
  );

  resv_dpath #(.ADDR_W(ADDR_W), .DATA_W(64), .GRAN_BYTES(GRAN_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqSo(reqSo), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .clearRsv(clearRsv), .memRdata(memRdata), .rsvValid(rsvValid), .memWe(memWe),
    .memDbl(memDbl), .memAddr(memAddr), .memWdata(memWdata), .rspData(rspData),
    .rspCr(rspCr)
  );
endmodule

// File: tb/sim_resv_unit.sv
`timescale 1ns/1ps
module sim_resv_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 0, req1Valid = 0, reqSo = 0, snoopValid = 0, clearRsv = 0;
  logic [1:0]  reqOp = 0;
  logic [31:0] reqAddr = 0, snoopAddr = 0;
  logic [63:0] reqData = 0;
  logic        reqReady, memReq, memWe, memDbl, memAck, rspValid, errAlign, errIllegal;
  logic [31:0] memAddr;
  logic [63:0] memWdata, memRdata, rspData;
  logic [3:0]  rspCr;
  logic        req1Ready, mem1Req, mem1We, mem1Dbl, mem1Ack, rsp1Valid, err1Align, err1Ill;
  logic [31:0] mem1Addr;
  logic [63:0] mem1Wdata, rsp1Data;
  logic [3:0]  rsp1Cr;

  resv_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqSo(reqSo), .snoopValid(snoopValid),
    .snoopAddr(snoopAddr), .clearRsv(clearRsv), .memReq(memReq), .memWe(memWe),
    .memDbl(memDbl), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .rspValid(rspValid), .rspData(rspData), .rspCr(rspCr),
    .errAlign(errAlign), .errIllegal(errIllegal));

  resv_unit #(.MODE64(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(req1Valid), .reqReady(req1Ready), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqSo(reqSo), .snoopValid(1'b0),
    .snoopAddr(32'd0), .clearRsv(1'b0), .memReq(mem1Req), .memWe(mem1We),
    .memDbl(mem1Dbl), .memAddr(mem1Addr), .memWdata(mem1Wdata), .memAck(mem1Ack),
    .memRdata(64'd0), .rspValid(rsp1Valid), .rspData(rsp1Data), .rspCr(rsp1Cr),
    .errAlign(err1Align), .errIllegal(err1Ill));

  // memory model: ack one cycle after request, data from address
  int accCnt = 0, wrCnt = 0;
  logic [31:0] lastWrAddr = 0;
  logic [63:0] lastWrData = 0;
  logic        lastWrDbl = 0;
  initial begin memAck = 0; mem1Ack = 0; end
  assign memRdata = {memAddr ^ 32'h5A5A0000, memAddr + 32'h01230000};
  always @(posedge clk) begin
    memAck  <= memReq && !memAck;
    mem1Ack <= mem1Req && !mem1Ack;
    if (memReq && memAck) begin
      accCnt <= accCnt + 1;
      if (memWe) begin
        wrCnt <= wrCnt + 1; lastWrAddr <= memAddr; lastWrData <= memWdata; lastWrDbl <= memDbl;
      end
    end
  end

  function automatic logic [63:0] expW(input logic [31:0] a);
    return {32'd0, a + 32'h01230000};
  endfunction
  function automatic logic [63:0] expD(input logic [31:0] a);
    return {a ^ 32'h5A5A0000, a + 32'h01230000};
  endfunction

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] data; logic [3:0] cr; logic al; logic il;
    int acc; int wr; bit wrChk; logic [31:0] wrAddr; logic [63:0] wrData; logic wrDbl;
    string tag;
  } exp_t;
  exp_t q[$];
  int accExp = 0, wrExp = 0;

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (q.size() == 0) chk("R11 unexpected response", 64'd1, 64'd0);
      else begin
        exp_t it;
        it = q.pop_front();
        chk({it.tag, " data"}, rspData, it.data);
        chk({it.tag, " R5 cr"}, {60'd0, rspCr}, {60'd0, it.cr});
        chk({it.tag, " R7 align"}, {63'd0, errAlign}, {63'd0, it.al});
        chk({it.tag, " R8 illegal"}, {63'd0, errIllegal}, {63'd0, it.il});
        chk({it.tag, " accesses"}, 64'(accCnt), 64'(it.acc));
        chk({it.tag, " writes"}, 64'(wrCnt), 64'(it.wr));
        if (it.wrChk) begin
          chk({it.tag, " wr addr"}, {32'd0, lastWrAddr}, {32'd0, it.wrAddr});
          chk({it.tag, " wr data"}, lastWrData, it.wrData);
          chk({it.tag, " wr size"}, {63'd0, lastWrDbl}, {63'd0, it.wrDbl});
        end
      end
    end
  end

  // driver
  task automatic doReq(input logic [1:0] op, input logic [31:0] a, input logic [63:0] d,
                       input logic so, input logic [63:0] eData, input logic [3:0] eCr,
                       input logic eAl, input logic eIl, input bit eAcc, input bit eWr,
                       input logic [63:0] eWrData, input bit clrMid, input string tag);
    exp_t it;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    if (eAcc) accExp++;
    if (eWr) wrExp++;
    it.data = eData; it.cr = eCr; it.al = eAl; it.il = eIl; it.acc = accExp; it.wr = wrExp;
    it.wrChk = eWr; it.wrAddr = a; it.wrData = eWrData; it.wrDbl = op[0]; it.tag = tag;
    q.push_back(it);
    reqValid = 1; reqOp = op; reqAddr = a; reqData = d; reqSo = so;
    @(negedge clk);
    reqValid = 0;
    chk({tag, " R11 ready low while busy"}, {63'd0, reqReady}, 64'd0);
    if (clrMid) begin
      @(negedge clk); clearRsv = 1;
      @(negedge clk); clearRsv = 0;
    end
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lrw(input logic [31:0] a, input string tag);
    doReq(2'd0, a, 64'd0, 0, expW(a), 4'b0000, 0, 0, 1, 0, 64'd0, 0, tag);
  endtask
  task automatic scw(input logic [31:0] a, input logic [63:0] d, input logic so, input bit ok, input string tag);
    doReq(2'd2, a, d, so, 64'd0, {2'b00, ok, so}, 0, 0, ok, ok, {32'd0, d[31:0]}, 0, tag);
  endtask
  task automatic pulse(input bit isSnoop, input logic [31:0] a);
    @(negedge clk);
    if (isSnoop) begin snoopValid = 1; snoopAddr = a; end else clearRsv = 1;
    @(negedge clk);
    snoopValid = 0; clearRsv = 0;
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {63'd0, reqReady}, 64'd1);
    chk("R11 reset rsp", {63'd0, rspValid}, 64'd0);
    chk("R11 reset memReq", {63'd0, memReq}, 64'd0);
    rstN = 1;
    @(negedge clk);

    scw(32'h100, 64'h1111, 0, 0, "R4 no reservation");
    scw(32'h100, 64'h1111, 1, 0, "R5 so copy no reservation");
    lrw(32'h40, "R1 load word");
    scw(32'h40, 64'hFFFF_0000_CAFE_BABE, 0, 1, "R3 store with reservation");
    scw(32'h40, 64'h2222, 1, 0, "R3 reservation gone");
    doReq(2'd1, 32'h80, 64'd0, 0, expD(32'h80), 4'b0000, 0, 0, 1, 0, 64'd0, 0, "R1 load double");
    doReq(2'd3, 32'h200, 64'h0123_4567_89AB_CDEF, 1, 64'd0, 4'b0011, 0, 0, 1, 1,
          64'h0123_4567_89AB_CDEF, 0, "R6 other address double store");
    lrw(32'h48, "R2 word reserve");
    doReq(2'd3, 32'h48, 64'hAAAA_BBBB_CCCC_DDDD, 0, 64'd0, 4'b0010, 0, 0, 1, 1,
          64'hAAAA_BBBB_CCCC_DDDD, 0, "R2 double store after word reserve");
    doReq(2'd1, 32'h88, 64'd0, 0, expD(32'h88), 4'b0000, 0, 0, 1, 0, 64'd0, 0, "R2 double reserve");
    scw(32'h88, 64'h5555, 0, 1, "R2 word store after double reserve");
    lrw(32'h10, "R1 first reserve");
    lrw(32'h20, "R1 replacing reserve");
    pulse(1, 32'h10);
    scw(32'h20, 64'h6, 0, 1, "R1 old address snoop ignored");
    lrw(32'h30, "R9 reserve");
    pulse(1, 32'h34);
    scw(32'h30, 64'h7, 0, 0, "R9 same granule snoop clears");
    lrw(32'h30, "R9 reserve again");
    pulse(1, 32'h38);
    scw(32'h30, 64'h8, 0, 1, "R9 other granule snoop kept");
    doReq(2'd0, 32'h42, 64'd0, 0, 64'd0, 4'b0000, 1, 0, 0, 0, 64'd0, 0, "R7 misaligned word load");
    lrw(32'h50, "R7 reserve");
    doReq(2'd3, 32'h54, 64'h9, 1, 64'd0, 4'b0000, 1, 0, 0, 0, 64'd0, 0, "R7 misaligned double store");
    scw(32'h50, 64'hA, 0, 1, "R7 reservation kept after error");
    lrw(32'h60, "R10 reserve");
    pulse(0, 32'h0);
    scw(32'h60, 64'hB, 0, 0, "R10 external clear");
    doReq(2'd0, 32'h70, 64'd0, 0, expW(32'h70), 4'b0000, 0, 0, 1, 0, 64'd0, 1, "R10 clear at load completion");
    scw(32'h70, 64'hC, 0, 0, "R10 clear wins over set");
    lrw(32'h74, "R10 reserve before reset");
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1; @(negedge clk);
    scw(32'h74, 64'hD, 0, 0, "R10 reset clears");

    // 32-bit build
    reqOp = 2'd1; reqAddr = 32'h80; req1Valid = 1;
    @(negedge clk); req1Valid = 0;
    chk("R8 double in 32-bit mode illegal", {61'd0, rsp1Valid, err1Ill, err1Align}, {61'd0, 3'b110});
    chk("R8 no access", {63'd0, mem1Req}, 64'd0);
    @(negedge clk);
    reqOp = 2'd3; reqAddr = 32'h84; req1Valid = 1;
    @(negedge clk); req1Valid = 0;
    chk("R8 illegal before alignment", {61'd0, rsp1Valid, err1Ill, err1Align}, {61'd0, 3'b110});
    @(negedge clk);
    reqOp = 2'd0; reqAddr = 32'h42; req1Valid = 1;
    @(negedge clk); req1Valid = 0;
    chk("R7 word misaligned in 32-bit mode", {61'd0, rsp1Valid, err1Ill, err1Align}, {61'd0, 3'b101});

    repeat (3) @(negedge clk);
    chk("R11 no stray responses", 64'(q.size()), 64'd0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule